// File: doc/BRIEF.md
# Memory-map access router

The router takes one CPU access per handshake (a 32-bit byte address, a size of byte, halfword or word, a direction, a sign flag and store data) and steers it to one of several region-local memories: two general RAMs, an IO register space, a palette store, a video store, an object-attribute store, a read-only cartridge image and a byte-wide backup RAM. The region is chosen by address bits 31:24. The offset inside a region is the address masked to that region's size, so each region mirrors across its window.

Decoding is width-aware. Some regions refuse some widths, and the video store has its own mirror mask and store bounds. Misaligned word loads come back rotated, and IO word loads are built from two halfword registers. Loads of a byte or halfword are sign- or zero-extended to 32 bits. The cartridge image is computed rather than stored, and any read at or beyond the image length returns zero.

Requests use a valid/ready channel, and load responses use a second valid/ready channel. A load answers exactly one cycle after it is accepted, and a store gives no response. A response that is not taken holds its data and blocks new requests. A new request is accepted in any cycle where no response is pending, or where the pending one is consumed in that same cycle.

Top module: `memmap_router`

## Requirements
- R1: Address bits 31:24 select the region: 0x02 general RAM A, 0x03 general RAM B, 0x04 IO, 0x05 palette, 0x06 video, 0x07 object attributes, 0x08 to 0x0D cartridge image, 0x0E backup RAM. Every other code, including 0x00, reads as 0 and ignores stores. At most one region memory is written per store.
- R2: The in-region offset is the address ANDed with (region bytes - 1), so every region repeats across its window. Stores to general RAM A and B succeed at all three sizes.
- R3: A word load returns the word at offset & ~3, rotated right by 8*addr[1:0].
- R4: A halfword load ignores addr[0] and takes the upper half when addr[1]=1. A byte load takes lane addr[1:0]. With req_signed=1 the value is sign-extended from bit 15 (halfword) or bit 7 (byte); with req_signed=0 it is zero-extended.
- R5: Byte stores to IO, palette, video and object regions are dropped. Byte loads from palette, video and object regions return 0.
- R6: An IO byte load returns the high byte of the halfword at the even address when addr[0]=1. An IO word load places the halfword at the offset in bits 15:0 and the halfword at (offset | 2) in bits 31:16, and is then rotated as in R3.
- R7: Video offsets use mask (2^VRAM_OFS_W - 1). Loads at an offset of VRAM_BYTES or more return 0. A word store is dropped at an offset of VRAM_BYTES-2 or more, and a halfword store is dropped at an offset of VRAM_BYTES or more.
- R8: All six cartridge windows alias one image with a 25-bit offset. The word at word index w is {~w[15:0], w[22:7] ^ w[15:0] ^ 16'h5A96}. A load whose masked byte offset is at or above rom_size returns 0. Stores to the cartridge image are ignored.
- R9: Backup RAM is byte-only. Halfword and word loads from it return 0, and halfword and word stores to it are ignored.
- R10: A load accepted at a clock edge raises rsp_valid at that edge plus one cycle. A store accepted alone leaves rsp_valid low afterwards.
- R11: req_ready equals !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, rsp_rdata holds stable.
- R12: After reset, rsp_valid is 0 and req_ready is 1.
- R13: Size code 2'b11 is reserved. Such a load returns 0, and such a store changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend byte and halfword loads |
| req_wdata | input | 32 | Store data, right-aligned |
| rom_size | input | 25 | Cartridge image length in bytes |
| rsp_valid | output | 1 | Load data present |
| rsp_ready | input | 1 | Consumer takes load data |
| rsp_rdata | output | 32 | Formatted load data |

## Verification
Two events can land in the same cycle: the hand-off of a pending load response and the acceptance of the next request, which may be a load that reloads the response registers or a store that writes a region memory. The bench drives rsp_ready at random during long mixed runs, and it also forces directed stalls that end with a new load in the releasing cycle. Each cycle it compares req_ready against the rule and compares the visible response against a scoreboard value, which it computed from its byte model at the moment of acceptance. A response that changed during a stall, or a request taken while blocked, therefore shows up as a data or ordering mismatch.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // RAM-backed kinds are numbered 1..7 so that slot g maps to kind g+1
  typedef enum logic [3:0] {
    RK_NONE = 4'd0,
    RK_WRAM = 4'd1,
    RK_IRAM = 4'd2,
    RK_IO   = 4'd3,
    RK_PAL  = 4'd4,
    RK_VRAM = 4'd5,
    RK_OAM  = 4'd6,
    RK_BKUP = 4'd7,
    RK_ROM  = 4'd8
  } rkind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } asize_e;

  localparam int unsigned NUM_RAMS = 7;
  localparam int unsigned ROM_OW   = 25;

  function automatic rkind_e region_kind(input logic [7:0] code);
    rkind_e k;
    case (code)
      8'h02: k = RK_WRAM;
      8'h03: k = RK_IRAM;
      8'h04: k = RK_IO;
      8'h05: k = RK_PAL;
      8'h06: k = RK_VRAM;
      8'h07: k = RK_OAM;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: k = RK_ROM;
      8'h0E: k = RK_BKUP;
      default: k = RK_NONE;
    endcase
    return k;
  endfunction

  // Cartridge image word at word index w (computed, not stored)
  function automatic logic [31:0] rom_word(input logic [22:0] w);
    return {~w[15:0], w[22:7] ^ w[15:0] ^ 16'h5A96};
  endfunction

endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import memmap_pkg::*;
#(
  parameter int unsigned WRAM_BYTES = 1024,
  parameter int unsigned IRAM_BYTES = 1024,
  parameter int unsigned IO_BYTES   = 1024,
  parameter int unsigned PAL_BYTES  = 1024,
  parameter int unsigned OAM_BYTES  = 1024,
  parameter int unsigned VRAM_OFS_W = 13,
  parameter int unsigned VRAM_BYTES = 6144,
  parameter int unsigned BKUP_BYTES = 256
) (
  input  logic [31:0]       addr,
  input  asize_e            size,
  input  logic [ROM_OW-1:0] rom_size,
  input  logic [31:0]       wdata,
  output rkind_e            kind,
  output logic [ROM_OW-1:0] off,
  output logic              ld_zero,
  output logic              st_ok,
  output logic [3:0]        be,
  output logic [31:0]       wlane
);

  localparam logic [ROM_OW-1:0] M_WRAM = ROM_OW'(WRAM_BYTES - 1);
  localparam logic [ROM_OW-1:0] M_IRAM = ROM_OW'(IRAM_BYTES - 1);
  localparam logic [ROM_OW-1:0] M_IO   = ROM_OW'(IO_BYTES - 1);
  localparam logic [ROM_OW-1:0] M_PAL  = ROM_OW'(PAL_BYTES - 1);
  localparam logic [ROM_OW-1:0] M_OAM  = ROM_OW'(OAM_BYTES - 1);
  localparam logic [ROM_OW-1:0] M_VRAM = ROM_OW'((1 << VRAM_OFS_W) - 1);
  localparam logic [ROM_OW-1:0] M_BKUP = ROM_OW'(BKUP_BYTES - 1);
  localparam logic [ROM_OW-1:0] V_LIM  = ROM_OW'(VRAM_BYTES);
  localparam logic [ROM_OW-1:0] V_LIM2 = ROM_OW'(VRAM_BYTES - 2);

  logic [ROM_OW-1:0] mask;
  logic              vid_only;

  always_comb begin
    kind = region_kind(addr[31:24]);
    case (kind)
      RK_WRAM: mask = M_WRAM;
      RK_IRAM: mask = M_IRAM;
      RK_IO:   mask = M_IO;
      RK_PAL:  mask = M_PAL;
      RK_VRAM: mask = M_VRAM;
      RK_OAM:  mask = M_OAM;
      RK_BKUP: mask = M_BKUP;
      RK_ROM:  mask = '1;
      default: mask = '0;
    endcase
    off = addr[ROM_OW-1:0] & mask;
  end

  // load zeroing and store acceptance follow the width rules per region
  always_comb begin
    vid_only = (kind == RK_PAL) || (kind == RK_VRAM) || (kind == RK_OAM);
    ld_zero  = (kind == RK_NONE) || (size == SZ_RSVD)
            || (vid_only && size == SZ_BYTE)
            || (kind == RK_BKUP && size != SZ_BYTE)
            || (kind == RK_ROM && off >= rom_size)
            || (kind == RK_VRAM && off >= V_LIM);
    st_ok = 1'b0;
    case (kind)
      RK_WRAM, RK_IRAM:      st_ok = (size != SZ_RSVD);
      RK_IO, RK_PAL, RK_OAM: st_ok = (size == SZ_HALF) || (size == SZ_WORD);
      RK_VRAM: st_ok = (size == SZ_HALF && off < V_LIM)
                    || (size == SZ_WORD && off < V_LIM2);
      RK_BKUP: st_ok = (size == SZ_BYTE);
      default: st_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (size)
      SZ_BYTE: begin be = 4'b0001 << off[1:0];             wlane = {4{wdata[7:0]}};  end
      SZ_HALF: begin be = off[1] ? 4'b1100 : 4'b0011;       wlane = {2{wdata[15:0]}}; end
      SZ_WORD: begin be = 4'b1111;                          wlane = wdata;            end
      default: begin be = 4'b0000;                          wlane = wdata;            end
    endcase
  end

endmodule

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned IW    = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  localparam bit FULL = (WORDS == (1 << IW));

  logic [31:0] mem [WORDS];
  logic        in_rng;

  generate
    if (FULL) begin : g_full
      assign in_rng = 1'b1;
    end else begin : g_part
      assign in_rng = (32'(widx) < WORDS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we && in_rng) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (rd_en) rdata <= in_rng ? mem[widx] : '0;
  end

endmodule

// File: rtl/mm_format.sv
module mm_format
  import memmap_pkg::*;
(
  input  rkind_e      kind,
  input  asize_e      size,
  input  logic        sgn,
  input  logic [1:0]  lo2,
  input  logic        zero,
  input  logic [31:0] word,
  output logic [31:0] data
);

  logic [31:0] io_word;
  logic [31:0] rot;
  logic [15:0] half;
  logic [7:0]  byt;

  always_comb begin
    // IO word: addressed half low, the (offset|2) half high
    io_word = (kind == RK_IO) ? {word[31:16], (lo2[1] ? word[31:16] : word[15:0])} : word;
    rot     = 32'({io_word, io_word} >> {lo2, 3'b000});
    half    = lo2[1] ? word[31:16] : word[15:0];
    byt     = 8'(word >> {lo2, 3'b000});
    case (size)
      SZ_WORD: data = rot;
      SZ_HALF: data = {{16{sgn & half[15]}}, half};
      SZ_BYTE: data = {{24{sgn & byt[7]}}, byt};
      default: data = '0;
    endcase
    if (zero) data = '0;
  end

endmodule

// File: rtl/memmap_router.sv
module memmap_router
  import memmap_pkg::*;
#(
  parameter int unsigned WRAM_BYTES = 1024,
  parameter int unsigned IRAM_BYTES = 1024,
  parameter int unsigned IO_BYTES   = 1024,
  parameter int unsigned PAL_BYTES  = 1024,
  parameter int unsigned OAM_BYTES  = 1024,
  parameter int unsigned VRAM_OFS_W = 13,
  parameter int unsigned VRAM_BYTES = 6144,
  parameter int unsigned BKUP_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_wdata,
  input  logic [24:0] rom_size,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata
);

  // slot order matches rkind_e values 1..7
  localparam int unsigned RAM_BYTES [NUM_RAMS] = '{WRAM_BYTES, IRAM_BYTES, IO_BYTES,
                                                   PAL_BYTES, VRAM_BYTES, OAM_BYTES, BKUP_BYTES};
  localparam int unsigned RAM_OW [NUM_RAMS] = '{$clog2(WRAM_BYTES), $clog2(IRAM_BYTES),
                                                $clog2(IO_BYTES), $clog2(PAL_BYTES), VRAM_OFS_W,
                                                $clog2(OAM_BYTES), $clog2(BKUP_BYTES)};

  rkind_e            dec_kind;
  logic [ROM_OW-1:0] dec_off;
  logic              dec_zero, dec_st_ok;
  logic [3:0]        dec_be;
  logic [31:0]       dec_wlane;
  logic              accept, ld_acc;
  logic [NUM_RAMS-1:0] ram_we;
  logic [31:0]       ram_q [NUM_RAMS];

  rkind_e      kind_q;
  asize_e      size_q;
  logic        sgn_q, zero_q;
  logic [1:0]  lo2_q;
  logic [31:0] rom_q, word_sel;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign ld_acc    = accept && !req_write;

  mm_decode #(
    .WRAM_BYTES(WRAM_BYTES), .IRAM_BYTES(IRAM_BYTES), .IO_BYTES(IO_BYTES),
    .PAL_BYTES(PAL_BYTES), .OAM_BYTES(OAM_BYTES), .VRAM_OFS_W(VRAM_OFS_W),
    .VRAM_BYTES(VRAM_BYTES), .BKUP_BYTES(BKUP_BYTES)
  ) u_dec (
    .addr(req_addr), .size(asize_e'(req_size)), .rom_size(rom_size), .wdata(req_wdata),
    .kind(dec_kind), .off(dec_off), .ld_zero(dec_zero), .st_ok(dec_st_ok),
    .be(dec_be), .wlane(dec_wlane)
  );

  generate
    for (genvar g = 0; g < NUM_RAMS; g++) begin : g_ram
      localparam int unsigned OW = RAM_OW[g];
      localparam int unsigned WORDS = RAM_BYTES[g] / 4;
      logic sel;
      assign sel       = (dec_kind == rkind_e'(4'(g + 1)));
      assign ram_we[g] = accept && req_write && sel && dec_st_ok;
      mm_ram #(.WORDS(WORDS), .IW(OW - 2)) u_ram (
        .clk(clk), .rd_en(ld_acc && sel), .we(ram_we[g]), .be(dec_be),
        .widx(dec_off[OW-1:2]), .wdata(dec_wlane), .rdata(ram_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (accept) begin
      rsp_valid <= !req_write;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_acc) begin
      kind_q <= dec_kind;
      size_q <= asize_e'(req_size);
      sgn_q  <= req_signed;
      zero_q <= dec_zero;
      lo2_q  <= dec_off[1:0];
      rom_q  <= rom_word(dec_off[24:2]);
    end
  end

  always_comb begin
    word_sel = (kind_q == RK_ROM) ? rom_q : '0;
    for (int i = 0; i < NUM_RAMS; i++) begin
      if (kind_q == rkind_e'(4'(i + 1))) word_sel = ram_q[i];
    end
  end

  mm_format u_fmt (
    .kind(kind_q), .size(size_q), .sgn(sgn_q), .lo2(lo2_q),
    .zero(zero_q), .word(word_sel), .data(rsp_rdata)
  );

  // R12: response channel idle after reset
  a_r12_reset_idle: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R10: accepted load answers next cycle, lone store does not
  a_r10_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid);
  a_r10_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid);

  // R11: stalled response is held
  a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R1: at most one region memory written
  a_r1_single_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_we));

  // R5: byte stores to IO/palette/video/object regions reach no memory
  a_r5_byte_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && req_size == 2'd0 &&
     (req_addr[31:24] inside {8'h04, 8'h05, 8'h06, 8'h07})) |-> (ram_we == '0));

  // R7: word store into video store stays below the size-2 bound
  a_r7_vram_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we[4] && req_size == 2'd2) |-> (dec_off < ROM_OW'(VRAM_BYTES - 2)));

  // R9: backup RAM written only by byte stores
  a_r9_bkup_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we[6] |-> (req_size == 2'd0));

endmodule

// File: tb/memmap_router_tb_top.sv
`timescale 1ns/1ps
module memmap_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, rsp_ready = 1'b0;
  logic        req_ready, rsp_valid;
  logic [31:0] req_addr = '0, req_wdata = '0, rsp_rdata;
  logic [1:0]  req_size = '0;
  logic [24:0] rom_size = 25'h400;

  int unsigned n_chk = 0, n_err = 0;
  bit          pend = 1'b0;
  logic [31:0] exp_val = '0;
  string       exp_tag = "R10";

  logic [7:0] m_wram [1024];
  logic [7:0] m_iram [1024];
  logic [7:0] m_io   [1024];
  logic [7:0] m_pal  [1024];
  logic [7:0] m_vram [6144];
  logic [7:0] m_oam  [1024];
  logic [7:0] m_bk   [256];

  always #2 clk = ~clk;

  memmap_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_wdata(req_wdata), .rom_size(rom_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(logic [7:0] r);
    case (r)
      8'h02: return 1; 8'h03: return 2; 8'h04: return 3; 8'h05: return 4;
      8'h06: return 5; 8'h07: return 6; 8'h0E: return 7;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned mask_of(int k);
    case (k)
      5: return 8191; 7: return 255; 8: return 32'h1FFFFFF; 0: return 0;
      default: return 1023;
    endcase
  endfunction

  function automatic logic [31:0] romw(logic [22:0] w);
    return {~w[15:0], w[22:7] ^ w[15:0] ^ 16'h5A96};
  endfunction

  function automatic logic [7:0] rd_b(int k, int unsigned o);
    case (k)
      1: return m_wram[o]; 2: return m_iram[o]; 3: return m_io[o];
      4: return m_pal[o];  5: return m_vram[o]; 6: return m_oam[o];
      7: return m_bk[o];
      8: return 8'(romw(23'(o >> 2)) >> (8 * (o & 3)));
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr_b(int k, int unsigned o, logic [7:0] b);
    case (k)
      1: m_wram[o] = b; 2: m_iram[o] = b; 3: m_io[o] = b;
      4: m_pal[o] = b;  5: m_vram[o] = b; 6: m_oam[o] = b;
      7: m_bk[o] = b;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] ref_load(logic [31:0] a, logic [1:0] sz, bit sg);
    int k;
    int unsigned o, bb, hb;
    logic [31:0] w;
    logic [15:0] h;
    logic [7:0]  b;
    k = kind_of(a[31:24]);
    o = a & mask_of(k);
    if (k == 0 || sz == 2'd3) return 0;
    if ((k == 4 || k == 5 || k == 6) && sz == 2'd0) return 0;
    if (k == 7 && sz != 2'd0) return 0;
    if (k == 8 && o >= 32'(rom_size)) return 0;
    if (k == 5 && o >= 6144) return 0;
    if (sz == 2'd2) begin
      bb = o & ~32'd3;
      w = {rd_b(k, bb + 3), rd_b(k, bb + 2), rd_b(k, bb + 1), rd_b(k, bb)};
      if (k == 3) w = {w[31:16], ((o & 2) != 0) ? w[31:16] : w[15:0]};
      return 32'({w, w} >> (8 * (o & 3)));
    end else if (sz == 2'd1) begin
      hb = o & ~32'd1;
      h = {rd_b(k, hb + 1), rd_b(k, hb)};
      return {{16{sg & h[15]}}, h};
    end
    b = rd_b(k, o);
    return {{24{sg & b[7]}}, b};
  endfunction

  task automatic ref_store(logic [31:0] a, logic [31:0] d, logic [1:0] sz);
    int k;
    int unsigned o, bb;
    k = kind_of(a[31:24]);
    o = a & mask_of(k);
    if (k == 0 || k == 8 || sz == 2'd3) return;
    if (sz == 2'd0) begin
      if (k >= 3 && k <= 6) return;
      wr_b(k, o, d[7:0]);
    end else if (sz == 2'd1) begin
      if (k == 7 || (k == 5 && o >= 6144)) return;
      bb = o & ~32'd1;
      wr_b(k, bb, d[7:0]); wr_b(k, bb + 1, d[15:8]);
    end else begin
      if (k == 7 || (k == 5 && o >= 6142)) return;
      bb = o & ~32'd3;
      for (int i = 0; i < 4; i++) wr_b(k, bb + i, d[8*i +: 8]);
    end
  endtask

  function automatic string tag_of(logic [31:0] a, logic [1:0] sz, bit sg);
    int k;
    k = kind_of(a[31:24]);
    if (sz == 2'd3) return "R13";
    case (k)
      0: return "R1"; 3: return "R6"; 4, 6: return "R5"; 5: return "R7";
      7: return "R9"; 8: return "R8";
      default: begin
        if (sz == 2'd2 && a[1:0] != 2'b00) return "R3";
        if (sz != 2'd2 && sg) return "R4";
        return "R2";
      end
    endcase
  endfunction

  // one cycle: observe the response, then drive the next request
  task automatic step(string tag, bit v, logic [31:0] a, logic [31:0] d,
                      logic [1:0] sz, bit w, bit sg, bit rdy);
    bit erdy;
    @(negedge clk);
    chk("R10", 32'(rsp_valid), 32'(pend));
    if (pend) chk(exp_tag, rsp_rdata, exp_val);
    rsp_ready = rdy;
    req_valid = v; req_addr = a; req_wdata = d; req_size = sz;
    req_write = w; req_signed = sg;
    #1;
    erdy = !rsp_valid || rdy;
    chk("R11", 32'(req_ready), 32'(erdy));
    if (pend && rdy) pend = 1'b0;
    if (v && erdy) begin
      if (!w) begin
        exp_val = ref_load(a, sz, sg);
        exp_tag = tag;
        pend = 1'b1;
      end else begin
        ref_store(a, d, sz);
      end
    end
  endtask

  task automatic ld(string tag, logic [31:0] a, logic [1:0] sz, bit sg);
    step(tag, 1'b1, a, '0, sz, 1'b0, sg, 1'b1);
  endtask

  task automatic st(logic [31:0] a, logic [31:0] d, logic [1:0] sz);
    step("R2", 1'b1, a, d, sz, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic idle();
    step("R10", 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: idle after reset
    chk("R12", 32'(rsp_valid), 32'd0);
    chk("R12", 32'(req_ready), 32'd1);

    // preload every region with word stores (backup with bytes)
    for (int i = 0; i < 1024; i += 4) begin
      st(32'h0200_0000 | i, $urandom, 2'd2);
      st(32'h0300_0000 | i, $urandom, 2'd2);
      st(32'h0400_0000 | i, $urandom, 2'd2);
      st(32'h0500_0000 | i, $urandom, 2'd2);
      st(32'h0700_0000 | i, $urandom, 2'd2);
    end
    for (int i = 0; i < 6144; i += 4) st(32'h0600_0000 | i, $urandom, 2'd2);
    for (int i = 0; i < 256; i++) st(32'h0E00_0000 | i, $urandom, 2'd0);

    // R1: unmapped and boot space read 0, ignore stores
    ld("R1", 32'h0000_0010, 2'd2, 1'b0);
    st(32'h0F00_0000, 32'hDEAD_BEEF, 2'd2);
    ld("R1", 32'h0F00_0000, 2'd2, 1'b0);
    ld("R1", 32'h1200_0004, 2'd2, 1'b0);
    // R2: mirror of general RAM A, byte and half stores
    st(32'h0200_0404, 32'h8081_F0F7, 2'd2);
    ld("R2", 32'h0200_0004, 2'd2, 1'b0);
    st(32'h0300_0009, 32'h0000_00C5, 2'd0);
    st(32'h0300_000E, 32'h0000_9A3C, 2'd1);
    ld("R2", 32'h0300_0008, 2'd2, 1'b0);
    ld("R2", 32'h0300_040C, 2'd2, 1'b0);
    // R3: rotation for each misalignment
    ld("R3", 32'h0300_0101, 2'd2, 1'b0);
    ld("R3", 32'h0300_0102, 2'd2, 1'b0);
    ld("R3", 32'h0300_0103, 2'd2, 1'b0);
    // R4: sign and zero extension, halfword ignores addr[0]
    ld("R4", 32'h0200_0006, 2'd1, 1'b1);
    ld("R4", 32'h0200_0007, 2'd1, 1'b0);
    ld("R4", 32'h0200_0004, 2'd0, 1'b1);
    ld("R4", 32'h0200_0005, 2'd0, 1'b1);
    ld("R4", 32'h0200_0007, 2'd0, 1'b0);
    // R5: byte stores dropped, byte loads zero
    st(32'h0500_0010, 32'h0000_00AA, 2'd0);
    ld("R5", 32'h0500_0010, 2'd2, 1'b0);
    st(32'h0700_0020, 32'h0000_0055, 2'd0);
    ld("R5", 32'h0700_0020, 2'd2, 1'b0);
    ld("R5", 32'h0700_0021, 2'd0, 1'b0);
    ld("R5", 32'h0600_0003, 2'd0, 1'b0);
    // R6: IO byte lanes and composed word
    st(32'h0400_0020, 32'hBEEF_1234, 2'd2);
    st(32'h0400_0010, 32'h0000_00FF, 2'd0);
    ld("R6", 32'h0400_0010, 2'd2, 1'b0);
    ld("R6", 32'h0400_0021, 2'd0, 1'b0);
    ld("R6", 32'h0400_0023, 2'd0, 1'b1);
    ld("R6", 32'h0400_0022, 2'd2, 1'b0);
    ld("R6", 32'h0400_0021, 2'd2, 1'b0);
    // R7: video bounds and mirror
    ld("R7", 32'h0600_1800, 2'd2, 1'b0);
    ld("R7", 32'h0600_3000, 2'd2, 1'b0);
    st(32'h0600_17FE, 32'h1111_2222, 2'd2);
    ld("R7", 32'h0600_17FC, 2'd2, 1'b0);
    st(32'h0600_17FD, 32'h3333_4444, 2'd2);
    ld("R7", 32'h0600_17FC, 2'd2, 1'b0);
    st(32'h0600_17FE, 32'h0000_5A5A, 2'd1);
    st(32'h0600_1800, 32'h0000_7777, 2'd1);
    ld("R7", 32'h0600_17FC, 2'd2, 1'b0);
    ld("R7", 32'h0600_37FE, 2'd1, 1'b0);
    // R8: cartridge aliasing, size limit, stores ignored
    ld("R8", 32'h0800_0010, 2'd2, 1'b0);
    ld("R8", 32'h0A00_0010, 2'd2, 1'b0);
    ld("R8", 32'h0C00_0012, 2'd1, 1'b1);
    ld("R8", 32'h0900_0010, 2'd2, 1'b0);
    ld("R8", 32'h0800_03FF, 2'd0, 1'b0);
    ld("R8", 32'h0800_0400, 2'd0, 1'b0);
    st(32'h0800_0010, 32'h0, 2'd2);
    ld("R8", 32'h0D00_0010, 2'd2, 1'b0);
    // R9: backup byte-only
    st(32'h0E00_0005, 32'h0000_00E7, 2'd0);
    ld("R9", 32'h0E00_0005, 2'd0, 1'b1);
    ld("R9", 32'h0E00_0004, 2'd1, 1'b0);
    st(32'h0E00_0004, 32'h1234_5678, 2'd2);
    st(32'h0E00_0004, 32'h0000_5678, 2'd1);
    ld("R9", 32'h0E00_0104, 2'd0, 1'b0);
    ld("R9", 32'h0E00_0105, 2'd0, 1'b0);
    ld("R9", 32'h0E00_0004, 2'd2, 1'b0);
    // R13: reserved size
    ld("R13", 32'h0200_0004, 2'd3, 1'b0);
    st(32'h0200_0004, 32'h0, 2'd3);
    ld("R13", 32'h0200_0004, 2'd2, 1'b0);
    // R11: stall, then release with a new load in the same cycle
    ld("R11", 32'h0300_0020, 2'd2, 1'b0);
    step("R11", 1'b1, 32'h0300_0024, '0, 2'd2, 1'b0, 1'b0, 1'b0);
    step("R11", 1'b1, 32'h0300_0024, '0, 2'd2, 1'b0, 1'b0, 1'b0);
    step("R11", 1'b1, 32'h0300_0024, '0, 2'd2, 1'b0, 1'b0, 1'b1);
    step("R11", 1'b1, 32'h0300_0024, 32'h0F0F_0F0F, 2'd2, 1'b1, 1'b0, 1'b1);
    ld("R11", 32'h0300_0024, 2'd2, 1'b0);
    // R10: store accepted alone leaves the response channel idle
    idle();
    idle();

    // constrained random mix with random back-pressure
    rom_size = 25'h600;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      logic [7:0]  r;
      logic [1:0]  sz;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: r = 8'h02; 1: r = 8'h03; 2: r = 8'h04; 3: r = 8'h05; 4: r = 8'h06;
        5: r = 8'h07; 6: r = 8'h0E; 7: r = 8'(8'h08 + $urandom_range(0, 5));
        8: r = 8'h02;
        default: r = 8'($urandom_range(0, 31));
      endcase
      a = {r, 24'($urandom & 32'h3FFF)};
      if (r >= 8'h08 && r <= 8'h0D) a[24] = 1'b0;
      sz = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      step(tag_of(a, sz, 1'b0), $urandom_range(0, 3) != 0, a, $urandom, sz,
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) != 0);
    end
    idle();
    idle();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule